// File: doc/BRIEF.md
# Wake and Notification Event Status Block

This block gathers hot-plug style event pulses into a 32-bit word of sticky status bits and turns them into system notifications. Each active status position has a matching enable bit. While the system sleeps, any status bit that is set and enabled raises a wake request. While the system is in its working state, the same condition raises a system control interrupt (SCI) or a system management interrupt (SMI), chosen by two routing controls.

Software reaches the block through a small register port with a valid/write/address/data request and a registered read response one cycle later. There are three registers. The status word is cleared by writing ones. The enable word is read/write. The control word holds the routing selects. Only positions 13 down to 7, 1 and 0 carry events. The other positions are tied to zero in both the status and the enable word.

Top module: `pm_evt_router`

## Requirements
- R1: Status and enable positions outside the active mask 0x0000_3F83 (bits 31:14 and 6:2) always read 0. Events and writes at those positions have no effect.
- R2: An event pulse at an active position sets that status bit at the next rising clock edge. The bit stays set after the pulse ends.
- R3: A write to the status register (offset 0x0) clears each active bit whose write-data bit is 1. Bits written with 0 keep their value.
- R4: After reset the status, enable and control registers are 0, and wake_req, sci_out and smi_out are low.
- R5: When an event and a write-1 clear hit the same status bit in the same cycle, the bit ends up set.
- R6: While sys_awake is 0, wake_req is high exactly when some status bit and its enable bit are both 1. A set status bit whose enable is 0 raises no output.
- R7: While sys_awake is 1 and control bit 0 (route to SCI) is 1, sci_out is high exactly when some enabled status bit is set, and smi_out stays low.
- R8: While sys_awake is 1 and control bit 0 is 0, smi_out follows the enabled status when control bit 1 (global SMI enable) is 1. When both control bits are 0, neither output rises.
- R9: A status bit set while asleep raises the routed SCI or SMI as soon as sys_awake returns to 1, unless software cleared it first. wake_req is low whenever sys_awake is 1.
- R10: A read request (valid=1, write=0) gives rsp_valid=1 with the register value in the next cycle. Offset 0x4 is the enable register. Offset 0x8 is the control register with bits 1:0 only. Any other offset reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 32 | Single-cycle event pulses, one per status position |
| sys_awake | input | 1 | 1 in the working state, 0 while asleep |
| req_valid | input | 1 | Register request strobe |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_addr | input | 4 | Register byte offset |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Read data valid, one cycle after a read request |
| rsp_rdata | output | 32 | Read data |
| wake_req | output | 1 | Wake request while asleep |
| sci_out | output | 1 | SCI level |
| smi_out | output | 1 | SMI level |

## Verification
The assertions take evt_in as a known value on every clock edge after reset. They also assume that a status bit falls only when a write-1 to offset 0x0 arrives with no event on that bit. The bench drives every input at the falling edge and holds evt_in at zero except during one-cycle pulses, so these assumptions hold. A scoreboard queue predicts each read response from the requirement values. Each test window ends on a falling edge, and the output levels are checked at that falling edge.

// File: rtl/pm_evt_router.sv
module pm_evt_router #(
  parameter int          DATA_W   = 32,
  parameter int          ADDR_W   = 4,
  parameter logic [31:0] ACT_MASK = 32'h0000_3F83
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] evt_in,
  input  logic              sys_awake,
  input  logic              req_valid,
  input  logic              req_write,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic              wake_req,
  output logic              sci_out,
  output logic              smi_out
);
  localparam logic [ADDR_W-1:0] STS_OFS = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] ENA_OFS = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] CTL_OFS = ADDR_W'(8);
  localparam logic [DATA_W-1:0] MASK    = ACT_MASK[DATA_W-1:0];

  logic [DATA_W-1:0] sts_q, ena_q, clr_vec, set_vec, rd_mux;
  logic              route_sci_q, smi_glb_q;
  logic              wr_sts, wr_ena, wr_ctl, pending;

  assign wr_sts  = req_valid && req_write && (req_addr == STS_OFS);
  assign wr_ena  = req_valid && req_write && (req_addr == ENA_OFS);
  assign wr_ctl  = req_valid && req_write && (req_addr == CTL_OFS);
  assign clr_vec = wr_sts ? (req_wdata & MASK) : '0;
  assign set_vec = evt_in & MASK;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sts_q       <= '0;
      ena_q       <= '0;
      route_sci_q <= 1'b0;
      smi_glb_q   <= 1'b0;
    end else begin
      sts_q <= (sts_q & ~clr_vec) | set_vec;
      if (wr_ena) ena_q <= req_wdata & MASK;
      if (wr_ctl) begin
        route_sci_q <= req_wdata[0];
        smi_glb_q   <= req_wdata[1];
      end
    end
  end

  always_comb begin
    rd_mux = '0;
    case (req_addr)
      STS_OFS: rd_mux = sts_q;
      ENA_OFS: rd_mux = ena_q;
      CTL_OFS: rd_mux = {{(DATA_W-2){1'b0}}, smi_glb_q, route_sci_q};
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_mux;
    end
  end

  assign pending  = |(sts_q & ena_q);
  assign wake_req = pending && !sys_awake;
  assign sci_out  = pending && sys_awake && route_sci_q;
  assign smi_out  = pending && sys_awake && !route_sci_q && smi_glb_q;

  AST_RSVD_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ((sts_q | ena_q) & ~MASK) == '0);  // R1
  AST_EVT_STICKS: assert property (@(posedge clk) disable iff (!rst_n)
    |evt_in |=> ((sts_q & $past(evt_in & MASK)) == $past(evt_in & MASK)));  // R2
  AST_NO_FREE_SET: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((sts_q & ~$past(sts_q) & ~$past(evt_in)) == '0));  // R2
  AST_CLR_BY_W1C: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (($past(sts_q) & ~sts_q & ~($past(clr_vec) & ~$past(evt_in))) == '0));  // R3
  AST_ROUTE_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
    !(sci_out && smi_out));  // R7
  AST_WAKE_ASLEEP: assert property (@(posedge clk) disable iff (!rst_n)
    wake_req |-> !sys_awake);  // R9
  AST_RSP_TIMING: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write) |=> rsp_valid);  // R10
endmodule

// File: tb/pm_evt_router_tb.sv
module pm_evt_router_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] evt_in = '0;
  logic        sys_awake = 1'b1;
  logic        req_valid = 1'b0, req_write = 1'b0;
  logic [3:0]  req_addr = '0;
  logic [31:0] req_wdata = '0;
  logic        rsp_valid, wake_req, sci_out, smi_out;
  logic [31:0] rsp_rdata;

  int n_cmp = 0, n_bad = 0;
  logic [31:0] exp_q[$];
  string       tag_q[$];

  always #4 clk = ~clk;

  pm_evt_router dut_i (
    .clk, .rst_n, .evt_in, .sys_awake, .req_valid, .req_write, .req_addr,
    .req_wdata, .rsp_valid, .rsp_rdata, .wake_req, .sci_out, .smi_out
  );

  always @(negedge clk) begin
    if (rst_n && rsp_valid) begin
      n_cmp++;
      if (exp_q.size() == 0) begin
        n_bad++;
        $display("FAIL R10 unexpected response: actual %h expected none", rsp_rdata);
      end else begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        if (rsp_rdata !== e) begin
          n_bad++;
          $display("FAIL %s read: actual %h expected %h", t, rsp_rdata, e);
        end
      end
    end
  end

  task automatic bus_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b1; req_addr = a; req_wdata = d;
    @(negedge clk);
    req_valid = 1'b0; req_write = 1'b0;
  endtask

  task automatic bus_rd(input logic [3:0] a, input logic [31:0] e, input string t);
    exp_q.push_back(e);
    tag_q.push_back(t);
    @(negedge clk);
    req_valid = 1'b1; req_write = 1'b0; req_addr = a;
    @(negedge clk);
    req_valid = 1'b0;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [31:0] v);
    @(negedge clk);
    evt_in = v;
    @(negedge clk);
    evt_in = '0;
  endtask

  task automatic chk_out(input string t, input logic w, input logic s, input logic m);
    n_cmp++;
    if ({wake_req, sci_out, smi_out} !== {w, s, m}) begin
      n_bad++;
      $display("FAIL %s outputs wake/sci/smi: actual %b%b%b expected %b%b%b",
               t, wake_req, sci_out, smi_out, w, s, m);
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    chk_out("R4", 0, 0, 0);
    bus_rd(4'h0, 32'h0, "R4 status");
    bus_rd(4'h4, 32'h0, "R4 enable");
    bus_rd(4'h8, 32'h0, "R4 control");

    bus_wr(4'h4, 32'hFFFF_FFFF);
    bus_rd(4'h4, 32'h0000_3F83, "R1 enable mask");
    pulse(32'hFFFF_FFFF);
    bus_rd(4'h0, 32'h0000_3F83, "R1/R2 status mask");
    chk_out("R8 both routes off", 0, 0, 0);

    bus_wr(4'h8, 32'h1);
    chk_out("R7 sci route", 0, 1, 0);
    bus_wr(4'h8, 32'h2);
    chk_out("R8 smi route", 0, 0, 1);
    bus_wr(4'h8, 32'h3);
    chk_out("R7 sci beats smi", 0, 1, 0);
    bus_wr(4'h8, 32'hFFFF_FFFF);
    bus_rd(4'h8, 32'h3, "R10 control width");
    bus_rd(4'hC, 32'h0, "R10 unmapped");

    bus_wr(4'h0, 32'h0000_0081);
    bus_rd(4'h0, 32'h0000_3F02, "R3 partial clear");
    bus_wr(4'h0, 32'h0);
    bus_rd(4'h0, 32'h0000_3F02, "R3 write zero");
    bus_wr(4'h0, 32'hFFFF_FFFF);
    bus_rd(4'h0, 32'h0, "R3 clear all");
    chk_out("R3 cleared", 0, 0, 0);

    pulse(32'h0000_007C);
    bus_rd(4'h0, 32'h0, "R1 reserved event");

    bus_wr(4'h8, 32'h1);
    bus_wr(4'h4, 32'h1);
    pulse(32'h0000_2000);
    chk_out("R6 disabled bit", 0, 0, 0);
    sys_awake = 1'b0;
    pulse(32'h0000_0001);
    chk_out("R6 wake asleep", 1, 0, 0);
    @(negedge clk); sys_awake = 1'b1;
    #1 chk_out("R9 sci on return", 0, 1, 0);
    bus_wr(4'h0, 32'hFFFF_FFFF);
    sys_awake = 1'b0;
    pulse(32'h0000_0001);
    bus_wr(4'h0, 32'h1);
    chk_out("R6 cleared asleep", 0, 0, 0);
    @(negedge clk); sys_awake = 1'b1;
    #1 chk_out("R9 cleared stays quiet", 0, 0, 0);

    @(negedge clk);
    evt_in = 32'h1;
    req_valid = 1'b1; req_write = 1'b1; req_addr = 4'h0; req_wdata = 32'h1;
    @(negedge clk);
    evt_in = '0; req_valid = 1'b0; req_write = 1'b0;
    bus_rd(4'h0, 32'h1, "R5 set wins");
    chk_out("R5 sci after set", 0, 1, 0);

    repeat (3) @(negedge clk);
    if (exp_q.size() != 0) begin
      n_bad++;
      $display("FAIL R10 missing responses: actual %0d pending expected 0", exp_q.size());
    end
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule